// File: doc/BRIEF.md
# Stereo DAC Gain and Soft-Mute Stage

This block scales a stereo stream of 18-bit signed samples before they reach the interpolation path of a digital-to-analog converter. Each channel is multiplied by an 8-bit gain code over 256. Code FFh is unity gain and code 00h silences the channel. New gain codes are first written into a staging store. They reach the signal path only when a write carries its load flag, and both channels switch on that same clock edge. A common-gain select lets the left code drive both channels.

Soft mute brings a shared mute level down by one code step per sample period, so the sound fades without a click. Releasing mute brings the level back up one step per sample period. Each channel's effective gain code is the smaller of its active code and the mute level. An output-disable bit forces both outputs to bipolar zero and keeps all settings. A zero-run detector counts bit-clock ticks while no nonzero sample arrives. After a configured run length it raises a flag that tells the analog stage to disconnect.

Top module: `dac_gain_stage`

## Requirements
- R1: After reset the active and staged gain codes on both channels are FFh, the mute level is FFh, out_valid is 0, both outputs are 0 and analog_off is 0.
- R2: With an effective code of FFh a sample passes unchanged. With any other code c the output is floor(sample * c / 256), rounded toward minus infinity for negative samples.
- R3: A write (wr_l or wr_r high) with wr_load at 0 only stores wr_code as that channel's staged code. Later samples keep using the previous gain.
- R4: A write with wr_load at 1 makes both staged codes active on the same edge, including the code carried by that write.
- R5: While common_sel is 1, the right channel uses the left active code and the right code has no effect. While common_sel is 0, each channel uses its own code.
- R6: Every accepted sample moves the mute level one step: down toward 0 while mute_en is 1, and up toward FFh while mute_en is 0. The output for a sample uses min(active code, mute level) as it stood before that step.
- R7: While zdet_en is 1, analog_off rises once ZERO_RUN bit_tick pulses have been seen with no nonzero sample since the last clear. It stays low after ZERO_RUN-1 pulses.
- R8: An accepted sample that is nonzero on either channel, or zdet_en at 0, clears the zero-run count. analog_off is then 0 from the next cycle on.
- R9: A sample accepted while out_dis is 1 produces 0 on both outputs. Gain and mute settings are kept, so the first sample after out_dis clears is scaled as programmed.
- R10: out_valid is high for exactly the cycle after each smp_valid cycle, and out_l and out_r change on that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_tick | input | 1 | One pulse per serial bit clock period, used by the zero-run counter |
| smp_valid | input | 1 | Sample strobe |
| smp_l | input | DATA_W | Left input sample, signed |
| smp_r | input | DATA_W | Right input sample, signed |
| wr_l | input | 1 | Write strobe for the left gain code |
| wr_r | input | 1 | Write strobe for the right gain code |
| wr_code | input | 8 | Gain code carried by a write |
| wr_load | input | 1 | Load flag of a write: apply both staged codes |
| common_sel | input | 1 | Left code drives both channels |
| mute_en | input | 1 | Soft mute request |
| zdet_en | input | 1 | Zero-run detection enable |
| out_dis | input | 1 | Force outputs to bipolar zero |
| out_valid | output | 1 | Output sample strobe |
| out_l | output | DATA_W | Left scaled sample, signed |
| out_r | output | DATA_W | Right scaled sample, signed |
| analog_off | output | 1 | Zero run detected, disconnect the analog output |

## Verification
The bench sends negative samples with non-power-of-two codes. A design that truncates toward zero instead of flooring is off by one on those samples. A write without the load flag is followed by a sample at the old gain, which catches a design that applies staged codes too early. A write to the right channel with the load flag is checked on both outputs, which catches a design that loads only the written channel. The mute ramp is checked one step at a time in both directions, and a design that steps by more than one code or jumps straight to silence gives a wrong value there. The zero-run flag is sampled one tick before and at the full run length, which catches an off-by-one in the threshold. The flag is also checked after a sample that is zero on the left and nonzero on the right, which catches a design that watches only one channel.

// File: rtl/atten_pkg.sv
package atten_pkg;
  localparam int CODE_W = 8;
  typedef logic [CODE_W-1:0] att_code_t;
  localparam att_code_t UNITY_CODE = '1;
  localparam att_code_t MUTE_CODE  = '0;

  function automatic att_code_t min_code(input att_code_t a, input att_code_t b);
    return (a < b) ? a : b;
  endfunction
endpackage

// File: rtl/gain_ctrl.sv
module gain_ctrl
  import atten_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      wr_l,
  input  logic      wr_r,
  input  att_code_t wr_code,
  input  logic      wr_load,
  input  logic      common_sel,
  output att_code_t act_l,
  output att_code_t act_r,
  output att_code_t chan_code_l,
  output att_code_t chan_code_r,
  output logic      load_evt
);
  att_code_t stage_l, stage_r;
  att_code_t next_l, next_r;

  assign load_evt = (wr_l | wr_r) & wr_load;
  assign next_l   = wr_l ? wr_code : stage_l;
  assign next_r   = wr_r ? wr_code : stage_r;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stage_l <= UNITY_CODE;
      stage_r <= UNITY_CODE;
      act_l   <= UNITY_CODE;
      act_r   <= UNITY_CODE;
    end else begin
      stage_l <= next_l;
      stage_r <= next_r;
      if (load_evt) begin
        act_l <= next_l;
        act_r <= next_r;
      end
    end
  end

  assign chan_code_l = act_l;
  assign chan_code_r = common_sel ? act_l : act_r;
endmodule

// File: rtl/mute_ramp.sv
module mute_ramp
  import atten_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      step,
  input  logic      mute_en,
  output att_code_t mute_lvl
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mute_lvl <= UNITY_CODE;
    end else if (step) begin
      if (mute_en && mute_lvl != MUTE_CODE)
        mute_lvl <= mute_lvl - 1'b1;
      else if (!mute_en && mute_lvl != UNITY_CODE)
        mute_lvl <= mute_lvl + 1'b1;
    end
  end
endmodule

// File: rtl/zero_run_det.sv
module zero_run_det #(
  parameter int ZERO_RUN = 65536
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic tick,
  input  logic nonzero,
  output logic run_hit
);
  localparam int CNT_W = $clog2(ZERO_RUN + 1);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(ZERO_RUN);

  logic [CNT_W-1:0] run_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n || !enable || nonzero)
      run_cnt <= '0;
    else if (tick && run_cnt != LIMIT)
      run_cnt <= run_cnt + 1'b1;
  end

  assign run_hit = (run_cnt == LIMIT);
endmodule

// File: rtl/chan_scaler.sv
module chan_scaler
  import atten_pkg::*;
#(
  parameter int DATA_W = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic              force_zero,
  input  logic [DATA_W-1:0] din,
  input  att_code_t         code,
  output logic [DATA_W-1:0] dout
);
  localparam int PROD_W = DATA_W + CODE_W + 1;

  function automatic logic [DATA_W-1:0] apply_gain(input logic [DATA_W-1:0] x,
                                                   input att_code_t c);
    logic signed [PROD_W-1:0] prod;
    prod = PROD_W'($signed(x)) * $signed({1'b0, c});
    if (c == UNITY_CODE) return x;
    return prod[CODE_W +: DATA_W];
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n)
      dout <= '0;
    else if (take)
      dout <= force_zero ? '0 : apply_gain(din, code);
  end
endmodule

// File: rtl/dac_gain_stage.sv
module dac_gain_stage
  import atten_pkg::*;
#(
  parameter int DATA_W   = 18,
  parameter int ZERO_RUN = 65536
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_tick,
  input  logic              smp_valid,
  input  logic [DATA_W-1:0] smp_l,
  input  logic [DATA_W-1:0] smp_r,
  input  logic              wr_l,
  input  logic              wr_r,
  input  logic [7:0]        wr_code,
  input  logic              wr_load,
  input  logic              common_sel,
  input  logic              mute_en,
  input  logic              zdet_en,
  input  logic              out_dis,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_l,
  output logic [DATA_W-1:0] out_r,
  output logic              analog_off
);
  localparam int NCH = 2;

  att_code_t act_l, act_r, chan_code_l, chan_code_r, mute_lvl;
  logic      load_evt;
  logic      smp_nonzero;

  att_code_t             eff_code [NCH];
  logic [DATA_W-1:0]     ch_in    [NCH];
  logic [DATA_W-1:0]     ch_out   [NCH];

  gain_ctrl u_gain (
    .clk, .rst_n, .wr_l, .wr_r, .wr_code(att_code_t'(wr_code)), .wr_load,
    .common_sel, .act_l, .act_r, .chan_code_l, .chan_code_r, .load_evt
  );

  mute_ramp u_mute (
    .clk, .rst_n, .step(smp_valid), .mute_en, .mute_lvl
  );

  assign smp_nonzero = smp_valid && (smp_l != '0 || smp_r != '0);

  zero_run_det #(.ZERO_RUN(ZERO_RUN)) u_zero (
    .clk, .rst_n, .enable(zdet_en), .tick(bit_tick),
    .nonzero(smp_nonzero), .run_hit(analog_off)
  );

  assign eff_code[0] = min_code(chan_code_l, mute_lvl);
  assign eff_code[1] = min_code(chan_code_r, mute_lvl);
  assign ch_in[0]    = smp_l;
  assign ch_in[1]    = smp_r;

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    chan_scaler #(.DATA_W(DATA_W)) u_scale (
      .clk, .rst_n, .take(smp_valid), .force_zero(out_dis),
      .din(ch_in[g]), .code(eff_code[g]), .dout(ch_out[g])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) out_valid <= 1'b0;
    else        out_valid <= smp_valid;
  end

  assign out_l = ch_out[0];
  assign out_r = ch_out[1];
endmodule

// File: rtl/dac_gain_stage_chk.sv
module dac_gain_stage_chk #(
  parameter int DATA_W = 18
) (
  input logic              clk,
  input logic              rst_n,
  input logic              smp_valid,
  input logic [DATA_W-1:0] smp_l,
  input logic [DATA_W-1:0] smp_r,
  input logic              wr_l,
  input logic              wr_r,
  input logic              wr_load,
  input logic              mute_en,
  input logic              zdet_en,
  input logic              out_dis,
  input logic              out_valid,
  input logic [DATA_W-1:0] out_l,
  input logic [DATA_W-1:0] out_r,
  input logic              analog_off,
  input logic [7:0]        act_l,
  input logic [7:0]        act_r,
  input logic [7:0]        mute_lvl
);
  a_r10_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid |=> out_valid);
  a_r10_valid_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_valid |=> !out_valid);
  a_r10_out_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_valid |=> ($stable(out_l) && $stable(out_r)));
  a_r3_no_load_keeps_gain: assert property (@(posedge clk) disable iff (!rst_n)
    ((wr_l || wr_r) && !wr_load) |=> ($stable(act_l) && $stable(act_r)));
  a_r6_ramp_down: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && mute_en && mute_lvl != 8'h00) |=> (mute_lvl == $past(mute_lvl) - 8'd1));
  a_r6_ramp_up: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && !mute_en && mute_lvl != 8'hFF) |=> (mute_lvl == $past(mute_lvl) + 8'd1));
  a_r6_level_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_valid |=> $stable(mute_lvl));
  a_r8_nonzero_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && (smp_l != '0 || smp_r != '0)) |=> !analog_off);
  a_r8_disable_clears: assert property (@(posedge clk) disable iff (!rst_n)
    !zdet_en |=> !analog_off);
  a_r9_force_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && out_dis) |=> (out_l == '0 && out_r == '0));
endmodule

bind dac_gain_stage dac_gain_stage_chk #(.DATA_W(DATA_W)) u_chk (
  .clk, .rst_n, .smp_valid, .smp_l, .smp_r, .wr_l, .wr_r, .wr_load,
  .mute_en, .zdet_en, .out_dis, .out_valid, .out_l, .out_r, .analog_off,
  .act_l, .act_r, .mute_lvl
);

// File: tb/dac_gain_stage_bench.sv
module dac_gain_stage_bench;
  localparam int DW = 18;
  localparam int ZR = 65536;

  logic clk = 0, rst_n = 0;
  logic bit_tick = 0, smp_valid = 0;
  logic [DW-1:0] smp_l = '0, smp_r = '0;
  logic wr_l = 0, wr_r = 0, wr_load = 0;
  logic [7:0] wr_code = '0;
  logic common_sel = 0, mute_en = 0, zdet_en = 0, out_dis = 0;
  logic out_valid, analog_off;
  logic [DW-1:0] out_l, out_r;

  int n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;

  dac_gain_stage u_dac_gain_stage (
    .clk, .rst_n, .bit_tick, .smp_valid, .smp_l, .smp_r, .wr_l, .wr_r,
    .wr_code, .wr_load, .common_sel, .mute_en, .zdet_en, .out_dis,
    .out_valid, .out_l, .out_r, .analog_off
  );

  function automatic int expect_gain(int x, int c);
    longint p;
    if (c == 255) return x;
    p = longint'(x) * c;
    if (p >= 0) return int'(p / 256);
    return int'((p - 255) / 256);
  endfunction

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send(int l, int r);
    @(negedge clk);
    smp_valid = 1; smp_l = DW'(l); smp_r = DW'(r);
    @(negedge clk);
    smp_valid = 0;
  endtask

  task automatic send_chk(string req, int l, int r, int el, int er);
    send(l, r);
    check({req, " valid"}, int'(out_valid), 1);
    check({req, " left"},  int'($signed(out_l)), el);
    check({req, " right"}, int'($signed(out_r)), er);
  endtask

  task automatic write_code(bit left, int code, bit ld);
    @(negedge clk);
    wr_l = left; wr_r = !left; wr_code = 8'(code); wr_load = ld;
    @(negedge clk);
    wr_l = 0; wr_r = 0; wr_load = 0;
  endtask

  task automatic ticks(int k);
    @(negedge clk);
    bit_tick = 1;
    repeat (k) @(negedge clk);
    bit_tick = 0;
  endtask

  task automatic t_reset;
    check("R1 valid", int'(out_valid), 0);
    check("R1 out_l", int'(out_l), 0);
    check("R1 out_r", int'(out_r), 0);
    check("R1 analog_off", int'(analog_off), 0);
    send_chk("R1 unity at reset", 77, -77, 77, -77);
  endtask

  task automatic t_gain_load;
    send_chk("R2 R10 unity", 1000, -1000, 1000, -1000);
    write_code(1, 8'h80, 0);
    send_chk("R3 staged only", 1000, -1000, 1000, -1000);
    write_code(0, 8'h40, 1);
    send_chk("R4 R2 both load", 1001, -1001,
             expect_gain(1001, 128), expect_gain(-1001, 64));
    send_chk("R2 odd code", -3, 5, expect_gain(-3, 128), expect_gain(5, 64));
  endtask

  task automatic t_common;
    common_sel = 1;
    send_chk("R5 common", 1001, -1001,
             expect_gain(1001, 128), expect_gain(-1001, 128));
    write_code(0, 8'h10, 0);
    send_chk("R5 right ignored", 600, -600,
             expect_gain(600, 128), expect_gain(-600, 128));
    common_sel = 0;
    write_code(1, 8'hFF, 0);
    write_code(0, 8'hFF, 1);
    send_chk("R5 individual again", 600, -600, 600, -600);
  endtask

  task automatic t_mute;
    mute_en = 1;
    send_chk("R6 step 255", 2000, -2000, 2000, -2000);
    send_chk("R6 step 254", 2000, -2000, expect_gain(2000, 254), expect_gain(-2000, 254));
    send_chk("R6 step 253", 2000, -2000, expect_gain(2000, 253), expect_gain(-2000, 253));
    for (int i = 0; i < 260; i++) send(2000, -2000);
    send_chk("R6 silent", 2000, -2000, 0, 0);
    mute_en = 0;
    send_chk("R6 release 0", 2000, -2000, 0, 0);
    send_chk("R6 release 1", 2000, -2000, expect_gain(2000, 1), expect_gain(-2000, 1));
    send_chk("R6 release 2", 2000, -2000, expect_gain(2000, 2), expect_gain(-2000, 2));
    for (int i = 0; i < 260; i++) send(2000, -2000);
    send_chk("R6 restored", 2000, -2000, 2000, -2000);
  endtask

  task automatic t_disable;
    write_code(1, 8'h80, 1);
    out_dis = 1;
    send_chk("R9 forced zero", 3000, -3000, 0, 0);
    out_dis = 0;
    send_chk("R9 settings kept", 3000, -3000, expect_gain(3000, 128), -3000);
  endtask

  task automatic t_zero;
    zdet_en = 1;
    @(negedge clk);
    check("R7 start low", int'(analog_off), 0);
    ticks(ZR - 1);
    check("R7 one short", int'(analog_off), 0);
    ticks(1);
    check("R7 run hit", int'(analog_off), 1);
    send(0, 5);
    check("R8 right nonzero clears", int'(analog_off), 0);
    ticks(ZR);
    check("R7 hit again", int'(analog_off), 1);
    send(0, 0);
    check("R7 zero sample keeps", int'(analog_off), 1);
    zdet_en = 0;
    @(negedge clk);
    check("R8 disable clears", int'(analog_off), 0);
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_gain_load();
    t_common();
    t_mute();
    t_disable();
    t_zero();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule